// File: doc/BRIEF.md
# Data Link Error Supervisor

This block watches the error events reported by the symbol decoder of a byte-oriented serial vehicle data link and decides how the node responds to each one. It takes single-cycle event pulses (break, bad symbol, framing error, CRC error, lost arbitration, end of frame), the bus level indications (passive, stuck at the active level, stuck at the passive level), and the node's own activity and requests. It drives the immediate abort lines for the transmitter and the receiver, the enables that gate new traffic, three sticky error flags, an interrupt request and a grant for a locally requested break symbol.

Symbol-level errors and a bus stuck at the active level put the link into lockout. In lockout both directions are disabled. The lockout ends only when the decoder reports an end-of-frame symbol while the bus is passive and no stuck-active short is present. A bus stuck at the passive level looks like an idle bus. It causes no lockout: it only holds off transmission, and it flags any transmit request made during the short. Transmission may start again in the same cycle the short clears.

Software reads the flags through a read strobe. That strobe clears them, but an error that arrives in the same cycle keeps its flag set.

Top module: `dl_err_supervisor`

## Requirements
- R1: `tx_abort` is high in the same cycle as `ev_break`, `ev_bad_sym`, `ev_frame_err` or `bus_stuck_act` whenever `tx_busy` is high.
- R2: `rx_abort` is high in the same cycle as `ev_break`, `ev_bad_sym` or `ev_frame_err` whenever `rx_busy` is high. A break seen with neither direction busy still locks the link.
- R3: `flag_sym` is set on the edge that samples a break, a bad symbol, a framing error, or a `tx_req` made while either bus short is present.
- R4: After a break, bad symbol, framing error or stuck-active sample, `tx_enable` and `rx_enable` are low from the next cycle on. They return high one cycle after a cycle that has `ev_eof` and `bus_passive` high, has `bus_stuck_act` low and carries no new locking error. An end of frame with the bus not passive does not end the lockout.
- R5: `irq` equals `irq_en` ANDed with the OR of the three flags, with no register between them.
- R6: `stat_rd` clears all three flags on the next edge. A flag whose set condition is present in the same cycle stays set.
- R7: `ev_crc_err` sets `flag_crc` and `ev_arb_lost` sets `flag_arb`. Neither event causes a lockout or an abort.
- R8: While `bus_stuck_act` is high, `tx_enable` is low. The short locks the link, and the lockout is not released by an end of frame that arrives while the short persists.
- R9: While `bus_stuck_pas` is high, `tx_enable` is low and `rx_enable` stays high, with no lockout. `tx_enable` returns high in the cycle the short drops.
- R10: `break_go` equals `brk_req` when the link is not locked and no bus short is present, and is low otherwise.
- R11: After reset the link is not locked, all flags are clear, and `tx_enable` and `rx_enable` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_break | input | 1 | Break symbol detected |
| ev_bad_sym | input | 1 | Invalid or out-of-range symbol |
| ev_frame_err | input | 1 | Framing error |
| ev_crc_err | input | 1 | CRC check failed |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_eof | input | 1 | Valid end-of-frame symbol |
| bus_passive | input | 1 | Bus currently at the passive level |
| bus_stuck_act | input | 1 | Bus shorted to the active level |
| bus_stuck_pas | input | 1 | Bus shorted to the passive level |
| tx_busy | input | 1 | Transmitter sending |
| rx_busy | input | 1 | Receiver taking a frame |
| tx_req | input | 1 | Transmit attempt |
| brk_req | input | 1 | Local request to send a break |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears flags |
| tx_abort | output | 1 | Abort transmission now |
| rx_abort | output | 1 | Drop the frame being received |
| tx_enable | output | 1 | New transmission permitted |
| rx_enable | output | 1 | Reception permitted |
| flag_sym | output | 1 | Sticky symbol or transmit error |
| flag_crc | output | 1 | Sticky CRC error |
| flag_arb | output | 1 | Sticky arbitration loss |
| irq | output | 1 | Interrupt request |
| break_go | output | 1 | Grant to send a break symbol |

## Verification
The abort lines, `irq`, `break_go` and the short-driven part of `tx_enable` are combinational, so they are due in the same cycle as their cause. The flags and the lockout state change on the edge that samples the cause, so they are due one cycle later. The bench drives each vector at the falling edge and holds it through the rising edge. It then samples all outputs one time unit after that rising edge. At that point the combinational outputs still reflect the held inputs and the registered outputs show the new state. Each expected vector is written for that point. The directed tests sample `irq` before any edge when they toggle only the enable.

// File: rtl/dl_err_pkg.sv
package dl_err_pkg;

   typedef enum logic {
      LNK_NORMAL = 1'b0,
      LNK_LOCKED = 1'b1
   } lnk_state_e;

   localparam int unsigned FLAG_SYM = 0;
   localparam int unsigned FLAG_CRC = 1;
   localparam int unsigned FLAG_ARB = 2;
   localparam int unsigned NUM_FLAGS = 3;

   typedef struct packed {
      logic brk;
      logic bad;
      logic frm;
      logic crc;
      logic arb;
      logic eof;
   } evt_t;

   typedef struct packed {
      logic passive;
      logic stuck_act;
      logic stuck_pas;
   } bus_t;

endpackage

// File: rtl/dl_err_classify.sv
module dl_err_classify
   import dl_err_pkg::*;
#(
   parameter bit STUCK_ACT_LOCKS = 1'b1
) (
   input  evt_t evt,
   input  bus_t bus,
   input  logic tx_busy,
   input  logic rx_busy,
   input  logic tx_req,
   output logic lock_err,
   output logic exit_ok,
   output logic tx_abort,
   output logic rx_abort,
   output logic sym_set,
   output logic short_any
);

   logic symbol_err;

   assign symbol_err = evt.brk | evt.bad | evt.frm;
   assign short_any  = bus.stuck_act | bus.stuck_pas;

   generate
      if (STUCK_ACT_LOCKS) begin : g_act_locks
         assign lock_err = symbol_err | bus.stuck_act;
      end else begin : g_act_nolock
         assign lock_err = symbol_err;
      end
   endgenerate

   assign exit_ok  = evt.eof & bus.passive & ~bus.stuck_act & ~lock_err;
   assign tx_abort = tx_busy & (symbol_err | bus.stuck_act);
   assign rx_abort = rx_busy & symbol_err;
   assign sym_set  = symbol_err | (tx_req & short_any);

endmodule

// File: rtl/dl_err_lockout.sv
module dl_err_lockout
   import dl_err_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock_err,
   input  logic       exit_ok,
   output lnk_state_e state
);

   lnk_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         LNK_NORMAL: if (lock_err) state_nxt = LNK_LOCKED;
         LNK_LOCKED: if (exit_ok)  state_nxt = LNK_NORMAL;
         default:    state_nxt = LNK_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LNK_NORMAL;
      else        state <= state_nxt;
   end

endmodule

// File: rtl/dl_err_flags.sv
module dl_err_flags #(
   parameter int unsigned      NF       = 3,
   parameter logic [NF-1:0]    CLR_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_vec,
   input  logic          rd,
   output logic [NF-1:0] flags
);

   initial begin
      if (NF < 1) $error("dl_err_flags: NF must be at least 1");
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      if (CLR_MASK[i]) begin : g_rc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (rd)         flags[i] <= 1'b0;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dl_err_supervisor.sv
module dl_err_supervisor
   import dl_err_pkg::*;
#(
   parameter bit                     STUCK_ACT_LOCKS = 1'b1,
   parameter logic [NUM_FLAGS-1:0]   RD_CLR_MASK     = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_break,
   input  logic ev_bad_sym,
   input  logic ev_frame_err,
   input  logic ev_crc_err,
   input  logic ev_arb_lost,
   input  logic ev_eof,
   input  logic bus_passive,
   input  logic bus_stuck_act,
   input  logic bus_stuck_pas,
   input  logic tx_busy,
   input  logic rx_busy,
   input  logic tx_req,
   input  logic brk_req,
   input  logic irq_en,
   input  logic stat_rd,
   output logic tx_abort,
   output logic rx_abort,
   output logic tx_enable,
   output logic rx_enable,
   output logic flag_sym,
   output logic flag_crc,
   output logic flag_arb,
   output logic irq,
   output logic break_go
);

   initial begin
      if (NUM_FLAGS != 3) $error("dl_err_supervisor: flag set must have three entries");
   end

   evt_t                 evt;
   bus_t                 bus;
   logic                 lock_err;
   logic                 exit_ok;
   logic                 sym_set;
   logic                 short_any;
   lnk_state_e           state;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] flags;
   logic                 link_open;

   assign evt = '{brk: ev_break, bad: ev_bad_sym, frm: ev_frame_err,
                  crc: ev_crc_err, arb: ev_arb_lost, eof: ev_eof};
   assign bus = '{passive: bus_passive, stuck_act: bus_stuck_act,
                  stuck_pas: bus_stuck_pas};

   dl_err_classify #(
      .STUCK_ACT_LOCKS(STUCK_ACT_LOCKS)
   ) u_classify (
      .evt      (evt),
      .bus      (bus),
      .tx_busy  (tx_busy),
      .rx_busy  (rx_busy),
      .tx_req   (tx_req),
      .lock_err (lock_err),
      .exit_ok  (exit_ok),
      .tx_abort (tx_abort),
      .rx_abort (rx_abort),
      .sym_set  (sym_set),
      .short_any(short_any)
   );

   dl_err_lockout u_lockout (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_err(lock_err),
      .exit_ok (exit_ok),
      .state   (state)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[FLAG_SYM] = sym_set;
      set_vec[FLAG_CRC] = evt.crc;
      set_vec[FLAG_ARB] = evt.arb;
   end

   dl_err_flags #(
      .NF      (NUM_FLAGS),
      .CLR_MASK(RD_CLR_MASK)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .rd     (stat_rd),
      .flags  (flags)
   );

   assign link_open = (state == LNK_NORMAL);
   assign rx_enable = link_open;
   assign tx_enable = link_open & ~short_any;
   assign break_go  = brk_req & link_open & ~short_any;
   assign flag_sym  = flags[FLAG_SYM];
   assign flag_crc  = flags[FLAG_CRC];
   assign flag_arb  = flags[FLAG_ARB];
   assign irq       = irq_en & (|flags);

endmodule

// File: rtl/dl_err_supervisor_chk.sv
module dl_err_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic ev_break,
   input logic ev_bad_sym,
   input logic ev_frame_err,
   input logic ev_crc_err,
   input logic ev_arb_lost,
   input logic ev_eof,
   input logic bus_passive,
   input logic bus_stuck_act,
   input logic bus_stuck_pas,
   input logic tx_busy,
   input logic rx_busy,
   input logic tx_req,
   input logic brk_req,
   input logic irq_en,
   input logic stat_rd,
   input logic tx_abort,
   input logic rx_abort,
   input logic tx_enable,
   input logic rx_enable,
   input logic flag_sym,
   input logic flag_crc,
   input logic flag_arb,
   input logic irq,
   input logic break_go
);

   logic sym_err;
   assign sym_err = ev_break | ev_bad_sym | ev_frame_err;

   assert_tx_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && (sym_err || bus_stuck_act)) |-> tx_abort);

   assert_rx_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_busy && sym_err) |-> rx_abort);

   assert_sym_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sym_err |=> flag_sym);

   assert_lock_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sym_err |=> (!rx_enable && !tx_enable));

   assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && !(ev_eof && bus_passive)) |=> !rx_enable);

   assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ev_crc_err) |=> !flag_crc);

   assert_stuck_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stuck_act |-> !tx_enable);

   assert_stuck_pas_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stuck_pas |-> (!tx_enable && !break_go));

endmodule

bind dl_err_supervisor dl_err_supervisor_chk u_chk (.*);

// File: tb/dl_err_supervisor_bench.sv
module dl_err_supervisor_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 20;

   // stimulus: brk bad frm crc arb eof | pas sa sp | txb rxb txr brq | ien rd
   // expect  : txab rxab | txen rxen | fsym fcrc farb irq | bgo
   localparam logic [23:0] VEC [NVEC] = '{
      {15'b000000_100_0000_00, 9'b00_11_0000_0}, // idle
      {15'b100000_000_1000_10, 9'b10_00_1001_0}, // R1 R3 R4 break in tx
      {15'b000001_000_0000_10, 9'b00_00_1001_0}, // R4 eof not passive
      {15'b000000_000_0000_11, 9'b00_00_0000_0}, // R6 read clears
      {15'b000001_100_0000_10, 9'b00_11_0000_0}, // R4 release
      {15'b001000_000_0100_00, 9'b01_00_1000_0}, // R2 frame err in rx, R5 no irq
      {15'b000001_100_0000_01, 9'b00_11_0000_0}, // R4 R6 release + read
      {15'b000100_000_0000_10, 9'b00_11_0101_0}, // R7 crc
      {15'b000010_000_0000_00, 9'b00_11_0110_0}, // R7 arb
      {15'b010000_000_0000_11, 9'b00_00_1001_0}, // R6 error wins
      {15'b000001_100_0000_01, 9'b00_11_0000_0}, // R4 release
      {15'b000000_001_0010_10, 9'b00_01_1001_0}, // R9 stuck passive tx attempt
      {15'b000000_000_0000_01, 9'b00_11_0000_0}, // R9 resume at once
      {15'b000000_010_1000_00, 9'b10_00_0000_0}, // R8 stuck active
      {15'b000001_010_0000_00, 9'b00_00_0000_0}, // R8 eof during short
      {15'b000001_100_0000_00, 9'b00_11_0000_0}, // R8 release
      {15'b000000_000_0001_00, 9'b00_11_0000_1}, // R10 break grant
      {15'b100000_000_0000_00, 9'b00_00_1000_0}, // R2 idle break locks
      {15'b000000_000_0001_00, 9'b00_00_1000_0}, // R10 no grant locked
      {15'b000001_100_0000_01, 9'b00_11_0000_0}  // R4 release
   };

   logic clk = 1'b0;
   logic rst_n;
   logic [14:0] stim;
   logic tx_abort, rx_abort, tx_enable, rx_enable;
   logic flag_sym, flag_crc, flag_arb, irq, break_go;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dl_err_supervisor u_dl_err_supervisor (
      .clk(clk), .rst_n(rst_n),
      .ev_break(stim[14]), .ev_bad_sym(stim[13]), .ev_frame_err(stim[12]),
      .ev_crc_err(stim[11]), .ev_arb_lost(stim[10]), .ev_eof(stim[9]),
      .bus_passive(stim[8]), .bus_stuck_act(stim[7]), .bus_stuck_pas(stim[6]),
      .tx_busy(stim[5]), .rx_busy(stim[4]), .tx_req(stim[3]), .brk_req(stim[2]),
      .irq_en(stim[1]), .stat_rd(stim[0]),
      .tx_abort(tx_abort), .rx_abort(rx_abort), .tx_enable(tx_enable),
      .rx_enable(rx_enable), .flag_sym(flag_sym), .flag_crc(flag_crc),
      .flag_arb(flag_arb), .irq(irq), .break_go(break_go)
   );

   function automatic logic [8:0] outs();
      return {tx_abort, rx_abort, tx_enable, rx_enable,
              flag_sym, flag_crc, flag_arb, irq, break_go};
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin
      stim  = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset", outs(), 9'b00_11_0000_0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk) stim = VEC[i][23:9];
         @(posedge clk);
         #1;
         check($sformatf("vec%0d", i), outs(), VEC[i][8:0]);
      end

      // R5: irq follows enable with no register
      @(negedge clk) stim = 15'b000100_000_0000_00;
      @(posedge clk);
      @(negedge clk) stim = 15'b000000_000_0000_00;
      #1 check("R5 irq off", outs(), 9'b00_11_0100_0);
      stim = 15'b000000_000_0000_10;
      #1 check("R5 irq comb", outs(), 9'b00_11_0101_0);

      // R11: reset during lockout
      @(negedge clk) stim = 15'b010000_000_0000_00;
      @(posedge clk);
      #1 check("R4 locked before reset", outs(), 9'b00_00_1100_0);
      @(negedge clk) begin stim = '0; rst_n = 1'b0; end
      #1 check("R11 reset mid-lock", outs(), 9'b00_11_0000_0);
      @(negedge clk) rst_n = 1'b1;

      // R1: bad symbol during tx aborts same cycle
      @(negedge clk) stim = 15'b010000_000_1000_00;
      #1 check("R1 comb abort", {tx_abort, rx_abort}, 2'b10);
      @(negedge clk) stim = '0;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 2000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule